// File: doc/BRIEF.md
# Oscillator Gearshift and Middle-Clock Controller

This controller runs in the domain of a single system oscillator. It decides whether that oscillator runs at its base rate or at its low rate, which is one eighth of the base rate (32 MHz and 4 MHz in the target use). The choice depends on the requested power mode and two configuration bits. From the same oscillator it also produces a middle-clock enable: a one-cycle pulse whose rate in real time stays at 4 MHz in both gears. At the base rate the pulse comes from a divide-by-8 counter. At the low rate every oscillator cycle carries a pulse.

A down-shift is applied only on the edge that ends a middle-clock pulse, and the divider is cleared on that edge. As a result, the last base-rate pulse and the first low-rate pulse are exactly one low-rate period apart. An up-shift takes effect on the next oscillator edge. The divider then restarts from zero, so the first divided pulse comes eight base cycles after the last pass-through pulse. The power mode request is registered once and reported back. There is no streaming data at this block's edge: every pin is a plain control or status signal.

Top module: `osc_gearshift`

## Requirements
- R1: During reset and right after it, `rate_low`=0, `mid_en`=0, `mode_cur`=0 (RUN) and `shift_pending`=0. The first `mid_en` pulse appears after the 7th rising edge following reset release.
- R2: At the base rate (`rate_low`=0) with no shift, `mid_en` is high for exactly one cycle in every 8, so any 16 consecutive cycles hold 2 pulses.
- R3: A down-shift (`rate_low` 0 to 1) takes effect only on an edge where `mid_en` was high. A low-rate request that arrives just after a pulse is held for 8 edges.
- R4: While `rate_low`=1, `mid_en` is high on every cycle.
- R5: When the low-rate target is withdrawn, `rate_low` falls on the next edge, and the next `mid_en` pulse follows exactly 8 edges after the last pass-through pulse.
- R6: Mode STOP (`mode_req`=2) with `stop_low_en`=0 and `low_always`=0 keeps the base rate.
- R7: With `low_always`=1 the low rate is used in RUN, SLEEP and STOP, whatever `stop_low_en` is.
- R8: Mode SLEEP (`mode_req`=1) and mode RUN (`mode_req`=0) use the base rate when `low_always`=0, even if `stop_low_en`=1.
- R9: `mode_cur` shows the mode requested before the previous edge, with encoding RUN=0, SLEEP=1, STOP=2. The unused code 3 is treated and reported as RUN.
- R10: `shift_pending` is high exactly while the gear selected by the current inputs differs from `rate_low`. While it is low, `rate_low` does not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| mode_req | input | 2 | Requested power mode (0 RUN, 1 SLEEP, 2 STOP) |
| stop_low_en | input | 1 | Use the low rate while in STOP |
| low_always | input | 1 | Low rate in every mode |
| rate_low | output | 1 | Oscillator rate select, 1 = low rate |
| mid_en | output | 1 | Middle-clock enable pulse |
| mode_cur | output | 2 | Registered power mode |
| shift_pending | output | 1 | Target gear differs from current gear |

## Verification
`shift_pending` is combinational and is due in the same cycle as its stimulus. `mode_cur` is due one edge after its stimulus. `rate_low` is due one edge after an up-shift request, and a down-shift is due on the first edge after `mid_en` has been high, which is up to 8 edges later. `mid_en` follows the divider state with no extra register. The bench drives and samples 2 ns after each rising edge and counts edges exactly to these points. The vector walk waits 9 edges before it measures, which covers the longest down-shift wait. The directed tests then check each transition on its exact edge, and also one edge early.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2
  } pm_e;
endpackage

// File: rtl/gs_target.sv
// Works out the normalized mode and the gear that the inputs call for.
module gs_target
  import gs_pkg::*;
(
  input  logic [1:0] mode_req,
  input  logic       stop_low_en,
  input  logic       low_always,
  output logic [1:0] mode_norm,
  output logic       want_low
);
  always_comb begin
    mode_norm = (mode_req == 2'd3) ? PM_RUN : mode_req;
    want_low  = low_always | ((mode_norm == PM_STOP) & stop_low_en);
  end
endmodule

// File: rtl/gs_divider.sv
// Base-rate divider: wraps at DIV-1 and is held at zero in low gear or when cleared.
module gs_divider #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_zero,
  output logic wrap
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (hold_zero)      cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = (cnt_q == LAST);
endmodule

// File: rtl/gs_gear.sv
// Gear register: shifts down only at a divider wrap, shifts up at once.
module gs_gear (
  input  logic clk,
  input  logic rst_n,
  input  logic want_low,
  input  logic wrap,
  output logic low_q,
  output logic clr_div
);
  logic go_down, go_up;

  always_comb begin
    go_down = !low_q && want_low && wrap;
    go_up   = low_q && !want_low;
    clr_div = go_down || go_up || low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_q <= 1'b0;
    else if (go_down) low_q <= 1'b1;
    else if (go_up)   low_q <= 1'b0;
  end
endmodule

// File: rtl/osc_gearshift.sv
module osc_gearshift #(
  parameter int DIV = 8
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       stop_low_en,
  input  logic       low_always,
  output logic       rate_low,
  output logic       mid_en,
  output logic [1:0] mode_cur,
  output logic       shift_pending
);
  import gs_pkg::*;

  logic [1:0] mode_norm;
  logic       want_low, wrap, low_q, clr_div;
  logic [1:0] mode_q;

  gs_target u_tgt (
    .mode_req   (mode_req),
    .stop_low_en(stop_low_en),
    .low_always (low_always),
    .mode_norm  (mode_norm),
    .want_low   (want_low)
  );

  gs_divider #(.DIV(DIV)) u_div (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .hold_zero(clr_div),
    .wrap     (wrap)
  );

  gs_gear u_gear (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .want_low(want_low),
    .wrap    (wrap),
    .low_q   (low_q),
    .clr_div (clr_div)
  );

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_norm;
  end

  assign rate_low      = low_q;
  assign mid_en        = low_q | wrap;
  assign mode_cur      = mode_q;
  assign shift_pending = want_low ^ low_q;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int DIV = 8
) (
  input logic       clk_osc,
  input logic       rst_n,
  input logic [1:0] mode_req,
  input logic       stop_low_en,
  input logic       low_always,
  input logic       rate_low,
  input logic       mid_en,
  input logic [1:0] mode_cur,
  input logic       shift_pending
);
  localparam int GW = $clog2(DIV) + 2;
  logic [GW-1:0] gap;

  // Cycles since the last middle-clock pulse, saturating.
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)                  gap <= '0;
    else if (mid_en)             gap <= '0;
    else if (gap != {GW{1'b1}})  gap <= gap + 1'b1;
  end

  a_r4_low_every_cycle: assert property (@(posedge clk_osc) disable iff (!rst_n)
    rate_low |-> mid_en);

  a_r3_down_aligned: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(rate_low) |-> $past(mid_en));

  a_r5_uniform_gap: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mid_en && !rate_low) |-> (gap == GW'(DIV - 1)));

  a_r10_no_pending_stable: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !shift_pending |=> $stable(rate_low));

  a_r6_stop_base: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_req == 2'd2 && !stop_low_en && !low_always && !rate_low) |=> !rate_low);

  a_r9_mode_stop: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_req == 2'd2) |=> (mode_cur == 2'd2));

  a_r9_mode_three_as_run: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_req == 2'd3) |=> (mode_cur == 2'd0));
endmodule

bind osc_gearshift gs_checker #(.DIV(DIV)) u_chk (
  .clk_osc      (clk_osc),
  .rst_n        (rst_n),
  .mode_req     (mode_req),
  .stop_low_en  (stop_low_en),
  .low_always   (low_always),
  .rate_low     (rate_low),
  .mid_en       (mid_en),
  .mode_cur     (mode_cur),
  .shift_pending(shift_pending)
);

// File: tb/sim_osc_gearshift.sv
`timescale 1ns/1ps
module sim_osc_gearshift;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic       stop_low_en = 1'b0;
  logic       low_always = 1'b0;
  logic       rate_low, mid_en, shift_pending;
  logic [1:0] mode_cur;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_gearshift #(.DIV(8)) u0 (
    .clk_osc(clk), .rst_n(rst_n), .mode_req(mode_req),
    .stop_low_en(stop_low_en), .low_always(low_always),
    .rate_low(rate_low), .mid_en(mid_en), .mode_cur(mode_cur),
    .shift_pending(shift_pending)
  );

  // mode, stop_low_en, low_always, expected rate, expected pulses in 16, expected mode_cur
  typedef struct packed {
    logic [1:0] md;
    logic       sle;
    logic       la;
    logic       rate;
    logic [4:0] pulses;
    logic [1:0] mcur;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 5'd2,  2'd0},  // R2 base run
    '{2'd2, 1'b1, 1'b0, 1'b1, 5'd16, 2'd2},  // R3 R4 stop low
    '{2'd0, 1'b1, 1'b0, 1'b0, 5'd2,  2'd0},  // R5 back to run
    '{2'd2, 1'b0, 1'b0, 1'b0, 5'd2,  2'd2},  // R6 stop without bit
    '{2'd1, 1'b1, 1'b0, 1'b0, 5'd2,  2'd1},  // R8 sleep
    '{2'd0, 1'b0, 1'b1, 1'b1, 5'd16, 2'd0},  // R7 always low run
    '{2'd1, 1'b0, 1'b1, 1'b1, 5'd16, 2'd1},  // R7 always low sleep
    '{2'd2, 1'b0, 1'b1, 1'b1, 5'd16, 2'd2},  // R7 always low stop
    '{2'd3, 1'b1, 1'b0, 1'b0, 5'd2,  2'd0}   // R9 code 3 as run
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic align_pulse();
    int guard = 0;
    while (!mid_en && guard < 20) begin edges(1); guard++; end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int first;
    // R1 reset state
    edges(3);
    chk("R1 rate", rate_low, 0);
    chk("R1 mid_en", mid_en, 0);
    chk("R1 mode_cur", mode_cur, 0);
    chk("R1 pending", shift_pending, 0);
    rst_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 10; k++) begin
      edges(1);
      if (mid_en && first == 0) first = k;
    end
    chk("R1 first pulse edge", first, 7);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      int cnt;
      mode_req = VEC[i].md; stop_low_en = VEC[i].sle; low_always = VEC[i].la;
      edges(9);
      chk($sformatf("R%0s rate v%0d", "x", i), rate_low, VEC[i].rate);
      chk($sformatf("R9 mode_cur v%0d", i), mode_cur, VEC[i].mcur);
      chk($sformatf("R10 settled pending v%0d", i), shift_pending, 0);
      cnt = 0;
      for (int k = 0; k < 16; k++) begin
        if (mid_en) cnt++;
        edges(1);
      end
      chk($sformatf("R2 R4 pulse count v%0d", i), cnt, VEC[i].pulses);
    end

    // R3 aligned down-shift
    mode_req = 2'd0; stop_low_en = 1'b0; low_always = 1'b0;
    edges(2);
    align_pulse();
    mode_req = 2'd2; stop_low_en = 1'b1;
    edges(1);
    chk("R3 aligned down after 1 edge", rate_low, 1);

    // R5 up-shift timing
    mode_req = 2'd0;
    #1;
    chk("R10 pending on up request", shift_pending, 1);
    edges(1);
    chk("R5 rate up after 1 edge", rate_low, 0);
    first = 0;
    for (int k = 1; k <= 10; k++) begin
      if (mid_en && first == 0) first = k;
      edges(1);
    end
    chk("R5 first divided pulse", first, 8);

    // R3 unaligned request held until the wrap
    align_pulse();
    edges(1);
    mode_req = 2'd2; stop_low_en = 1'b1;
    #1;
    chk("R10 pending on down request", shift_pending, 1);
    edges(7);
    chk("R3 held at edge 7", rate_low, 0);
    chk("R3 pulse at edge 7", mid_en, 1);
    edges(1);
    chk("R3 low at edge 8", rate_low, 1);
    chk("R4 low mid_en", mid_en, 1);

    // R7 stop_low_en ignored when always low
    low_always = 1'b1; stop_low_en = 1'b0; mode_req = 2'd0;
    edges(3);
    chk("R7 still low", rate_low, 1);
    chk("R9 mode_cur run", mode_cur, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule